// File: doc/BRIEF.md
# Static 3.5-Digit LCD Segment Driver

This block turns a latched decimal reading into the drive waveforms for a directly driven (static) liquid-crystal panel with three full seven-segment digits, a leading half-digit "1" and a minus sign. Each of the units, tens and hundreds BCD digits is decoded to seven segments. The leading "1" is one output that lights both of its bars. The minus sign follows a polarity input.

The glass must never see a lasting DC voltage, so the block makes a square-wave backplane by dividing the input clock. Each segment output is a copy of the backplane, inverted when the segment is to be lit. Every segment output and the backplane are loaded on the same clock edge, so they never drift apart.

A lamp-test input lights every segment and the minus sign, so the panel shows -1888. In that mode the backplane divider stops, and every segment sits at a steady level opposite to the frozen backplane.

Top module: `lcd_static_driver`

## Requirements
- R1: While rst_n is low, backplane and every segment output are 0.
- R2: With lamp_test low, backplane toggles once every BP_DIV/2 clock cycles, so its period is BP_DIV cycles (default 800). The first toggle after reset comes on the BP_DIV/2-th rising edge after release.
- R3: An unlit segment output equals backplane and a lit one equals its complement. Both are loaded on the same edge, from the inputs present one rising edge before.
- R4: Segment vector bit 0 is segment a, and bits 1 to 6 are b, c, d, e, f and g. BCD codes 0 to 9 light these segments: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 all seven, 9 abcdfg.
- R5: BCD codes 10 to 15 light no segment of that digit.
- R6: seg_thou is lit exactly when half_digit is 1.
- R7: seg_minus is lit exactly when negative is 1.
- R8: While lamp_test is 1, backplane holds its value and the divider count is frozen. All 23 segment outputs sit at the complement of backplane, whatever the digit inputs are. After release, counting resumes from the frozen count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| digit_units | input | 4 | Units BCD digit |
| digit_tens | input | 4 | Tens BCD digit |
| digit_hund | input | 4 | Hundreds BCD digit |
| half_digit | input | 1 | Leading "1" on |
| negative | input | 1 | Reading is negative |
| lamp_test | input | 1 | Light every segment with steady drive |
| backplane | output | 1 | Square-wave common electrode drive |
| seg_units | output | 7 | Units segments, bit 0 = a to bit 6 = g |
| seg_tens | output | 7 | Tens segments, bit 0 = a to bit 6 = g |
| seg_hund | output | 7 | Hundreds segments, bit 0 = a to bit 6 = g |
| seg_thou | output | 1 | Both bars of the leading "1" |
| seg_minus | output | 1 | Minus sign |

## Verification
All sixteen codes are swept through each digit position, with a different code in each position at once, so a crossed digit path or a wrong table row shows. Each setting is held for a full backplane period while half_digit and negative cycle, so both backplane phases are seen and a segment that stays static, or follows the wrong phase, is told apart from a correct one. The spacing between backplane toggles is measured over the whole run, including a lamp-test interval. That separates a divider that is frozen correctly from one that resets or keeps running during the test.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    typedef logic [6:0] seg7_t;

    typedef struct packed {
        seg7_t units;
        seg7_t tens;
        seg7_t hund;
        logic  thou;
        logic  minus;
    } lcd_drive_t;

endpackage

// File: rtl/lcd_bcd7.sv
module lcd_bcd7
    import lcd_pkg::*;
(
    input  logic [3:0] bcd,
    output seg7_t      seg
);

    // bit 0 = a ... bit 6 = g
    always_comb begin
        case (bcd)
            4'd0:    seg = 7'b0111111;
            4'd1:    seg = 7'b0000110;
            4'd2:    seg = 7'b1011011;
            4'd3:    seg = 7'b1001111;
            4'd4:    seg = 7'b1100110;
            4'd5:    seg = 7'b1101101;
            4'd6:    seg = 7'b1111101;
            4'd7:    seg = 7'b0000111;
            4'd8:    seg = 7'b1111111;
            4'd9:    seg = 7'b1101111;
            default: seg = 7'b0000000;   // R5: codes above nine are blank
        endcase
    end

endmodule

// File: rtl/lcd_bp_div.sv
module lcd_bp_div #(
    parameter int unsigned HALF  = 400,
    parameter int unsigned CNT_W = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic bp_q,
    output logic bp_d
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bp;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                st_d.bp  = ~st_q.bp;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bp_q = st_q.bp;
    assign bp_d = st_d.bp;

    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(bp_q));

    assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && st_q.cnt == LAST) |=> (bp_q != $past(bp_q)));

    assert_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && st_q.cnt != LAST) |=> $stable(bp_q));

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

endmodule

// File: rtl/lcd_static_driver.sv
module lcd_static_driver
    import lcd_pkg::*;
#(
    parameter int unsigned BP_DIV = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] digit_units,
    input  logic [3:0] digit_tens,
    input  logic [3:0] digit_hund,
    input  logic       half_digit,
    input  logic       negative,
    input  logic       lamp_test,
    output logic       backplane,
    output logic [6:0] seg_units,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_hund,
    output logic       seg_thou,
    output logic       seg_minus
);

    localparam int unsigned HALF   = BP_DIV / 2;
    localparam int unsigned CNT_W  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned NDIGIT = 3;

    logic [3:0] bcd_in  [NDIGIT];
    seg7_t      seg_dec [NDIGIT];
    logic       bp_now, bp_next;

    assign bcd_in[0] = digit_units;
    assign bcd_in[1] = digit_tens;
    assign bcd_in[2] = digit_hund;

    for (genvar g = 0; g < NDIGIT; g++) begin : g_dec
        lcd_bcd7 u_dec (
            .bcd (bcd_in[g]),
            .seg (seg_dec[g])
        );
    end

    lcd_bp_div #(
        .HALF  (HALF),
        .CNT_W (CNT_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (lamp_test),
        .bp_q  (bp_now),
        .bp_d  (bp_next)
    );

    lcd_drive_t lit;
    lcd_drive_t drv_d, drv_q;

    always_comb begin
        if (lamp_test) begin
            lit = '1;
        end else begin
            lit.units = seg_dec[0];
            lit.tens  = seg_dec[1];
            lit.hund  = seg_dec[2];
            lit.thou  = half_digit;
            lit.minus = negative;
        end
        // lit segments run opposite to the backplane value loaded on the same edge
        drv_d = lit ^ {$bits(lcd_drive_t){bp_next}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign backplane = bp_now;
    assign seg_units = drv_q.units;
    assign seg_tens  = drv_q.tens;
    assign seg_hund  = drv_q.hund;
    assign seg_thou  = drv_q.thou;
    assign seg_minus = drv_q.minus;

    assert_test_all_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_test |=> (seg_units == {7{~backplane}} && seg_tens == {7{~backplane}}
                       && seg_hund == {7{~backplane}} && seg_thou == ~backplane
                       && seg_minus == ~backplane));

    assert_minus_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lamp_test |=> (seg_minus == (backplane ^ $past(negative))));

    assert_thou_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lamp_test |=> (seg_thou == (backplane ^ $past(half_digit))));

    assert_blank_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lamp_test && digit_units > 4'd9) |=> (seg_units == {7{backplane}}));

    assert_eight_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lamp_test && digit_tens == 4'd8) |=> (seg_tens == {7{~backplane}}));

endmodule

// File: tb/lcd_static_driver_test.sv
module lcd_static_driver_test;

    localparam int DIV  = 8;
    localparam int HALF = DIV / 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] digit_units, digit_tens, digit_hund;
    logic       half_digit, negative, lamp_test;
    logic       backplane;
    logic [6:0] seg_units, seg_tens, seg_hund;
    logic       seg_thou, seg_minus;

    int vectors = 0;
    int errors  = 0;
    int run     = 0;
    logic prev_bp = 1'b0;
    bit done = 0;

    always #10 clk = ~clk;

    lcd_static_driver #(.BP_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n),
        .digit_units(digit_units), .digit_tens(digit_tens), .digit_hund(digit_hund),
        .half_digit(half_digit), .negative(negative), .lamp_test(lamp_test),
        .backplane(backplane),
        .seg_units(seg_units), .seg_tens(seg_tens), .seg_hund(seg_hund),
        .seg_thou(seg_thou), .seg_minus(seg_minus)
    );

    // segment sets of R4, bit 0 = a .. bit 6 = g; R5 blank above nine
    function automatic logic [6:0] want_seg(input logic [3:0] c);
        logic [6:0] s;
        case (c)
            4'd0: s = 7'b0111111;  4'd1: s = 7'b0000110;
            4'd2: s = 7'b1011011;  4'd3: s = 7'b1001111;
            4'd4: s = 7'b1100110;  4'd5: s = 7'b1101101;
            4'd6: s = 7'b1111101;  4'd7: s = 7'b0000111;
            4'd8: s = 7'b1111111;  4'd9: s = 7'b1101111;
            default: s = 7'b0000000;
        endcase
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one rising edge, then backplane spacing check (R2) or freeze check (R8)
    task automatic tick();
        logic held;
        held = lamp_test;
        @(negedge clk);
        if (held) begin
            check(backplane == prev_bp, "R8 backplane frozen", backplane, prev_bp);
        end else begin
            run++;
            if (backplane != prev_bp) begin
                check(run == HALF, "R2 toggle spacing", run, HALF);
                run = 0;
            end else begin
                check(run < HALF, "R2 late toggle", run, HALF);
            end
        end
        prev_bp = backplane;
    endtask

    task automatic apply(input logic [3:0] u, input logic [3:0] t, input logic [3:0] h,
                         input logic hd, input logic ng, input logic tst);
        logic [6:0] eu, et, eh;
        logic       eth, emi;
        digit_units = u; digit_tens = t; digit_hund = h;
        half_digit = hd; negative = ng; lamp_test = tst;
        tick();
        if (tst) begin
            eu = '1; et = '1; eh = '1; eth = 1'b1; emi = 1'b1;
        end else begin
            eu = want_seg(u); et = want_seg(t); eh = want_seg(h); eth = hd; emi = ng;
        end
        // R3: lit output is complement of backplane, unlit equals it
        check(seg_units == (eu ^ {7{backplane}}), tst ? "R8 units" : "R4 R5 R3 units", seg_units, eu ^ {7{backplane}});
        check(seg_tens  == (et ^ {7{backplane}}), tst ? "R8 tens"  : "R4 R5 R3 tens",  seg_tens,  et ^ {7{backplane}});
        check(seg_hund  == (eh ^ {7{backplane}}), tst ? "R8 hund"  : "R4 R5 R3 hund",  seg_hund,  eh ^ {7{backplane}});
        check(seg_thou  == (eth ^ backplane), tst ? "R8 thou" : "R6 thou", seg_thou, eth ^ backplane);
        check(seg_minus == (emi ^ backplane), tst ? "R8 minus" : "R7 minus", seg_minus, emi ^ backplane);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        digit_units = 4'd8; digit_tens = 4'd8; digit_hund = 4'd8;
        half_digit = 1'b1; negative = 1'b1; lamp_test = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(backplane == 1'b0, "R1 backplane", backplane, 0);
        check({seg_units, seg_tens, seg_hund, seg_thou, seg_minus} == '0, "R1 segments",
              {seg_units, seg_tens, seg_hund, seg_thou, seg_minus}, 0);
        rst_n = 1'b1;
        prev_bp = 1'b0;
        run = 0;

        // sweep every code through every digit, across both backplane phases
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < DIV; k++) begin
                apply(4'(c), 4'(c + 7), 4'(c + 13), k[0], k[1], 1'b0);
            end
        end

        // R8 lamp test with blank codes on the inputs, entered mid-count
        apply(4'd3, 4'd1, 4'd0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) apply(4'd15, 4'd11, 4'd10, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 2 * DIV; k++) apply(4'(k), 4'(9 - (k % 10)), 4'd8, k[1], k[0], 1'b0);
        for (int k = 0; k < 3; k++) apply(4'd0, 4'd0, 4'd0, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < DIV; k++) apply(4'd5, 4'd2, 4'd7, 1'b0, 1'b1, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule